// File: doc/BRIEF.md
# Masked Vector Bitwise AND Unit

This datapath block forms the bitwise AND of two vector operands inside a 512-bit destination register and returns the new destination value one cycle after a request strobe. The active vector length can be 64, 128, 256 or 512 bits. A mode select decides which operand acts as the first source and what happens to the destination bits above the active length. The two narrow keep modes preserve those bits. The clear and masked modes force them to zero.

In masked mode each element is enabled by one bit of a write mask. An element is 32 or 64 bits wide. A disabled element either keeps its old destination value (merge) or becomes zero (zero). Masked mode can also replicate the lowest element of the second source across all lanes when that source is flagged as coming from memory. A request with an illegal combination of controls leaves the destination unchanged and raises an error flag. No status flags are produced.

Top module: `vand_unit`

## Requirements
- R1: Inside the active length, each result bit is 1 only when both operand bits are 1. Mode encoding: 0 = narrow keep (64 bits), 1 = wide keep (128 bits), 2 = clear, 3 = masked. Length encoding (`len_sel`): 0 = 64 bits, 1 = 128 bits, 2 = 256 bits, 3 = 512 bits.
- R2: In masked mode with `mask_en`=1 and `zero_en`=0, an element whose mask bit is 0 keeps its old `dst_old` value.
- R3: In masked mode with `mask_en`=1 and `zero_en`=1, an element whose mask bit is 0 becomes zero.
- R4: With `elem64`=1, mask bit j governs result bits 64j+63..64j. With `elem64`=0, mask bit j governs bits 32j+31..32j.
- R5: In masked mode with `mask_en`=0, every element inside the length is written with the AND result, whatever the value of `mask`.
- R6: In masked mode with `bcast`=1 and `b_mem`=1, every lane uses the lowest 32-bit (`elem64`=0) or 64-bit (`elem64`=1) element of `src_b`. With `b_mem`=0 the broadcast flag has no effect.
- R7: In clear mode (allowed lengths 128 and 256) and in masked mode (allowed lengths 128, 256 and 512), all result bits at or above the active length are 0.
- R8: Wide keep mode (length 128) computes `dst_old[127:0] & src_b[127:0]` and keeps bits 511..128 of `dst_old`. `src_a` is not used.
- R9: Narrow keep mode (length 64) computes `dst_old[63:0] & src_b[63:0]` and keeps bits 511..64 of `dst_old`. `src_a` is not used.
- R10: Mask bits at or above the number of active lanes have no effect on the result.
- R11: `out_valid` is high for exactly one cycle, in the cycle after each `in_valid`. `out_dst` and `out_err` hold their values until the next request.
- R12: A request is illegal in any of these cases, and then `out_dst` equals `dst_old` and `out_err`=1:
  - `mask_en` or `bcast` is set in modes 0, 1 or 2;
  - the length does not fit the mode (mode 0 needs 64, mode 1 needs 128, mode 2 needs 128 or 256, mode 3 needs 128 or more).

  For a legal request, `out_err`=0.
- R13: After reset, `out_valid`=0, `out_err`=0 and `out_dst`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Mode select: 0 narrow keep, 1 wide keep, 2 clear, 3 masked |
| len_sel | input | 2 | Active length: 0=64, 1=128, 2=256, 3=512 bits |
| elem64 | input | 1 | Element size for masking and broadcast: 0 = 32 bits, 1 = 64 bits |
| mask_en | input | 1 | Enable the write mask (masked mode only) |
| zero_en | input | 1 | Disabled elements: 1 = zero, 0 = merge |
| bcast | input | 1 | Broadcast the lowest element of the second source |
| b_mem | input | 1 | Second source is flagged as a memory operand |
| mask | input | 16 | Per-element write mask |
| src_a | input | 512 | First source (clear and masked modes) |
| src_b | input | 512 | Second source |
| dst_old | input | 512 | Current destination value |
| out_valid | output | 1 | One-cycle result strobe |
| out_err | output | 1 | Illegal-combination flag for the last request |
| out_dst | output | 512 | New destination value |

## Verification
Broadcast and write masking can act on the same request. In that case each lane's mask bit decides between the broadcast AND result and the merge or zero value. The bench provokes this with 64-bit elements, a sparse mask, zeroing, and a memory-flagged broadcast. It judges every lane against a bit-by-bit reference that applies the broadcast index and the mask bit separately. A second pairing is masking with a short length while high mask bits are set. For that case the bench checks that the bits above the length are still zero and that the disabled low lanes follow the zeroing rule.

// File: rtl/vand_pkg.sv
package vand_pkg;
  typedef enum logic [1:0] {
    MD_NARROW = 2'd0,
    MD_WIDE   = 2'd1,
    MD_CLEAR  = 2'd2,
    MD_MASKED = 2'd3
  } vmode_e;
endpackage

// File: rtl/vand_ctrl.sv
module vand_ctrl #(
  parameter int DATA_W  = 512,
  parameter int CHUNK_W = 32,
  localparam int NCH    = DATA_W / CHUNK_W
) (
  input  logic [1:0]     mode,
  input  logic [1:0]     len_sel,
  input  logic           mask_en,
  input  logic           bcast,
  input  logic           b_mem,
  output logic           legal,
  output logic           keep_upper,
  output logic           mask_on,
  output logic           bcast_on,
  output logic [NCH-1:0] chunk_active
);
  import vand_pkg::*;

  vmode_e md;
  assign md = vmode_e'(mode);

  always_comb begin
    legal = 1'b0;
    unique case (md)
      MD_NARROW: legal = (len_sel == 2'd0) && !mask_en && !bcast;
      MD_WIDE:   legal = (len_sel == 2'd1) && !mask_en && !bcast;
      MD_CLEAR:  legal = ((len_sel == 2'd1) || (len_sel == 2'd2)) && !mask_en && !bcast;
      MD_MASKED: legal = (len_sel != 2'd0);
      default:   legal = 1'b0;
    endcase
  end

  assign keep_upper = (md == MD_NARROW) || (md == MD_WIDE);
  assign mask_on    = (md == MD_MASKED) && mask_en;
  assign bcast_on   = (md == MD_MASKED) && bcast && b_mem;

  // active chunk count = 64 bits << len_sel, expressed in chunks
  localparam int BASE_CH = 64 / CHUNK_W;
  logic [7:0] n_active;
  assign n_active = 8'(BASE_CH) << len_sel;

  for (genvar c = 0; c < NCH; c++) begin : g_act
    assign chunk_active[c] = (8'(c) < n_active);
  end
endmodule

// File: rtl/vand_bsel.sv
module vand_bsel #(
  parameter int DATA_W  = 512,
  parameter int CHUNK_W = 32,
  localparam int NCH    = DATA_W / CHUNK_W
) (
  input  logic              bcast_on,
  input  logic              elem64,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] b_eff
);
  for (genvar c = 0; c < NCH; c++) begin : g_b
    localparam int HALF = c % 2;
    always_comb begin
      if (!bcast_on)
        b_eff[c*CHUNK_W +: CHUNK_W] = src_b[c*CHUNK_W +: CHUNK_W];
      else if (elem64)
        b_eff[c*CHUNK_W +: CHUNK_W] = src_b[HALF*CHUNK_W +: CHUNK_W];
      else
        b_eff[c*CHUNK_W +: CHUNK_W] = src_b[CHUNK_W-1:0];
    end
  end
endmodule

// File: rtl/vand_lanes.sv
module vand_lanes #(
  parameter int DATA_W  = 512,
  parameter int CHUNK_W = 32,
  localparam int NCH    = DATA_W / CHUNK_W
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] b_eff,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [NCH-1:0]    chunk_active,
  input  logic [NCH-1:0]    mask,
  input  logic              keep_upper,
  input  logic              mask_on,
  input  logic              zero_en,
  input  logic              elem64,
  output logic [DATA_W-1:0] res
);
  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic [CHUNK_W-1:0] a_c, b_c, d_c;
    logic               mbit, wr_en;
    assign a_c   = keep_upper ? dst_old[c*CHUNK_W +: CHUNK_W] : src_a[c*CHUNK_W +: CHUNK_W];
    assign b_c   = b_eff[c*CHUNK_W +: CHUNK_W];
    assign d_c   = dst_old[c*CHUNK_W +: CHUNK_W];
    assign mbit  = elem64 ? mask[c/2] : mask[c];
    assign wr_en = !mask_on || mbit;
    always_comb begin
      if (!chunk_active[c])
        res[c*CHUNK_W +: CHUNK_W] = keep_upper ? d_c : '0;
      else if (wr_en)
        res[c*CHUNK_W +: CHUNK_W] = a_c & b_c;
      else
        res[c*CHUNK_W +: CHUNK_W] = zero_en ? '0 : d_c;
    end
  end
endmodule

// File: rtl/vand_unit.sv
module vand_unit #(
  parameter int DATA_W  = 512,
  parameter int CHUNK_W = 32,
  localparam int NCH    = DATA_W / CHUNK_W,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [1:0]        len_sel,
  input  logic              elem64,
  input  logic              mask_en,
  input  logic              zero_en,
  input  logic              bcast,
  input  logic              b_mem,
  input  logic [NCH-1:0]    mask,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] dst_old,
  output logic              out_valid,
  output logic              out_err,
  output logic [DATA_W-1:0] out_dst
);
  import vand_pkg::*;

  logic              legal, keep_upper, mask_on, bcast_on;
  logic [NCH-1:0]    chunk_active;
  logic [DATA_W-1:0] b_eff, res;

  vand_ctrl #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_ctrl (
    .mode(mode), .len_sel(len_sel), .mask_en(mask_en), .bcast(bcast), .b_mem(b_mem),
    .legal(legal), .keep_upper(keep_upper), .mask_on(mask_on), .bcast_on(bcast_on),
    .chunk_active(chunk_active)
  );

  vand_bsel #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_bsel (
    .bcast_on(bcast_on), .elem64(elem64), .src_b(src_b), .b_eff(b_eff)
  );

  vand_lanes #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_lanes (
    .src_a(src_a), .b_eff(b_eff), .dst_old(dst_old), .chunk_active(chunk_active),
    .mask(mask), .keep_upper(keep_upper), .mask_on(mask_on), .zero_en(zero_en),
    .elem64(elem64), .res(res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_dst   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_dst <= legal ? res : dst_old;
        out_err <= !legal;
      end
    end
  end

  assert_valid_latency_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_illegal_unchanged_R12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_dst == $past(dst_old)));

  assert_upper_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && ($past(mode) >= 2'd2) && ($past(len_sel) != 2'd3))
      |-> (out_dst[DATA_W-1:HALF_W] == '0));

  assert_wide_keep_upper_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && ($past(mode) == 2'd1))
      |-> (out_dst[DATA_W-1:128] == $past(dst_old[DATA_W-1:128])));

  assert_narrow_keep_upper_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && ($past(mode) == 2'd0))
      |-> (out_dst[DATA_W-1:64] == $past(dst_old[DATA_W-1:64])));
endmodule

// File: tb/tb_vand_unit.sv
`timescale 1ns/1ps
module tb_vand_unit;
  localparam int DW = 512;

  typedef struct packed {
    logic [1:0]  md;
    logic [1:0]  ln;
    logic        e64, men, zen, bc, bm;
    logic [15:0] mk;
    logic [31:0] sa, sb, sd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 32'hF0F0_A5A5, 32'hFF00_3C3C, 32'h1234_5678, 8'd1},  // R1
    '{2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 32'hFFFF_FFFF, 32'h0F0F_F0F0, 32'hDEAD_BEEF, 8'd7},  // R7
    '{2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hA5C3, 32'h5555_AAAA, 32'hFFFF_0000, 32'hCAFE_F00D, 8'd2},  // R2
    '{2'd3, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h3C5A, 32'h7777_1111, 32'hF0F0_FFFF, 32'h8888_9999, 8'd3},  // R3
    '{2'd3, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0005, 32'hAAAA_5555, 32'hFFFF_FFFF, 32'h0BAD_CAFE, 8'd4},  // R4
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 32'h3333_CCCC, 32'h0FF0_0FF0, 32'h1111_2222, 8'd5},  // R5
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 32'hFFFF_FFFF, 32'h1357_9BDF, 32'h2468_ACE0, 8'd6},  // R6
    '{2'd3, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h000B, 32'hFFFF_FFFF, 32'h8421_4218, 32'h5A5A_A5A5, 8'd6},  // R6 with mask
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 32'hFFFF_FFFF, 32'h9ABC_DEF0, 32'h0000_0000, 8'd6},  // R6 register
    '{2'd3, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFF0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7E7E_7E7E, 8'd10}, // R10
    '{2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 32'h0000_0000, 32'hF00F_0FF0, 32'hFFFF_1234, 8'd8},  // R8
    '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 32'h0000_0000, 32'h00FF_FF00, 32'hABCD_EF01, 8'd9},  // R9
    '{2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0003, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1357_2468, 8'd12}, // R12
    '{2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0F1E_2D3C, 8'd12}, // R12
    '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h4B5A_6978, 8'd12}, // R12
    '{2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8796_A5B4, 8'd12}  // R12
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    mode = '0, len_sel = '0;
  logic          elem64 = 1'b0, mask_en = 1'b0, zero_en = 1'b0, bcast = 1'b0, b_mem = 1'b0;
  logic [15:0]   mask = '0;
  logic [DW-1:0] src_a = '0, src_b = '0, dst_old = '0;
  logic          out_valid, out_err;
  logic [DW-1:0] out_dst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vand_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .len_sel(len_sel),
    .elem64(elem64), .mask_en(mask_en), .zero_en(zero_en), .bcast(bcast), .b_mem(b_mem),
    .mask(mask), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .out_valid(out_valid), .out_err(out_err), .out_dst(out_dst)
  );

  function automatic logic [DW-1:0] spread(input logic [31:0] seed);
    logic [DW-1:0] v;
    for (int c = 0; c < DW/32; c++) v[c*32 +: 32] = seed ^ (32'h9E37_79B9 * (c + 1));
    return v;
  endfunction

  function automatic logic [DW:0] model(input vec_t v, input logic [DW-1:0] a, b, d);
    logic [DW-1:0] r;
    bit ok;
    int vl, esz, bi;
    bit fa, on;
    case (v.md)
      2'd0: ok = (v.ln == 0) && !v.men && !v.bc;
      2'd1: ok = (v.ln == 1) && !v.men && !v.bc;
      2'd2: ok = (v.ln == 1 || v.ln == 2) && !v.men && !v.bc;
      default: ok = (v.ln != 0);
    endcase
    if (!ok) return {1'b1, d};
    vl  = 64 << v.ln;
    esz = v.e64 ? 64 : 32;
    for (int i = 0; i < DW; i++) begin
      if (i >= vl) r[i] = (v.md < 2) ? d[i] : 1'b0;
      else begin
        fa = (v.md < 2) ? d[i] : a[i];
        bi = (v.md == 3 && v.bc && v.bm) ? (i % esz) : i;
        on = !(v.md == 3 && v.men) || v.mk[i / esz];
        r[i] = on ? (fa & b[bi]) : (v.zen ? 1'b0 : d[i]);
      end
    end
    return {1'b0, r};
  endfunction

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog expired: actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW:0] exp;
    logic [DW-1:0] held;
    repeat (4) @(negedge clk);
    // R13: reset state
    chk(out_valid == 1'b0, 13, "reset out_valid", DW'(out_valid), '0);
    chk(out_err == 1'b0, 13, "reset out_err", DW'(out_err), '0);
    chk(out_dst == '0, 13, "reset out_dst", out_dst, '0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      mode = TBL[k].md; len_sel = TBL[k].ln; elem64 = TBL[k].e64;
      mask_en = TBL[k].men; zero_en = TBL[k].zen; bcast = TBL[k].bc; b_mem = TBL[k].bm;
      mask = TBL[k].mk;
      src_a = spread(TBL[k].sa); src_b = spread(TBL[k].sb); dst_old = spread(TBL[k].sd);
      exp = model(TBL[k], src_a, src_b, dst_old);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, 11, "strobe after request", DW'(out_valid), DW'(1));
      chk(out_err == exp[DW], int'(TBL[k].req), "error flag", DW'(out_err), DW'(exp[DW]));
      chk(out_dst == exp[DW-1:0], int'(TBL[k].req), "result", out_dst, exp[DW-1:0]);
      @(negedge clk);
    end

    // R11: single-cycle strobe and held result while inputs change
    held = out_dst;
    src_a = '1; src_b = '1; dst_old = '0;
    @(negedge clk);
    chk(out_valid == 1'b0, 11, "strobe low when idle", DW'(out_valid), '0);
    chk(out_dst == held, 11, "result held when idle", out_dst, held);

    // R10/R4 combined: 64-bit elements, 128-bit length, only upper mask bits set
    mode = 2'd3; len_sel = 2'd1; elem64 = 1'b1; mask_en = 1'b1; zero_en = 1'b1;
    bcast = 1'b0; b_mem = 1'b0; mask = 16'hFFFC;
    src_a = '1; src_b = '1; dst_old = '1;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_dst == '0, 10, "high mask bits ignored", out_dst, '0);
    chk(out_err == 1'b0, 10, "legal request no error", DW'(out_err), '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule